// File: doc/BRIEF.md
# Signed Serial-by-Parallel Multiplier

The block multiplies a signed operand held in a register by a signed operand that arrives one bit per clock, least significant bit first. The register operand is M bits wide and the serial operand N bits wide, both in two's complement. The product is M+N bits wide and leaves the block as a serial stream, one bit per clock. The datapath is a linear row of M cells. Each cell ANDs one bit of the register operand with the serial bit and adds that bit to the partial sum from the next more significant cell. The addition uses a one-bit full adder with a saved carry. The serial bit goes to every cell at once. Every other wire runs only between adjacent cells, so no carry chain spans the word. The most significant cell subtracts instead of adding, because that bit carries a negative weight.

To use the block, load the register operand while the block is idle. Raise the frame-start strobe in the same cycle as serial bit 0. Then drive the serial operand for M+N cycles, sign-extended beyond its N bits. The strobe clears every cell's saved carry and partial sum. Each product bit appears one clock after the matching serial input bit. A valid flag and a first-bit flag mark the output stream.

A two-state controller sequences each frame. In state ST_IDLE the block accepts operand loads and waits for the strobe. The transition "start" (strobe while idle) takes serial bit 0, clears the cells and moves to ST_RUN. ST_RUN takes the remaining M+N-1 serial bits. The transition "last bit" returns to ST_IDLE in the cycle that takes serial bit M+N-1. The transition "hold" keeps ST_IDLE when no strobe arrives. The transition "next bit" keeps ST_RUN before the last bit.

Top module: `serial_par_mult`

## Requirements
- R1: During and directly after reset, `busy`, `prod_valid`, `prod_first` and `prod_bit` are all 0.
- R2: For a register operand A and serial operand B, read as two's complement, the stream on `prod_bit` is the low M+N bits of A*B, least significant bit first.
- R3: A strobe on `frame_start` in ST_IDLE is sampled together with serial bit 0. In the following cycle `prod_first` and `prod_valid` are 1 and `prod_bit` is product bit 0. Product bit t appears one cycle after serial bit t is sampled.
- R4: Each frame yields exactly M+N consecutive cycles with `prod_valid` high. `prod_first` is high only in the first of them.
- R5: `op_load` copies `op_in` into the operand register only in ST_IDLE and only when `frame_start` is low. A load while `busy` is high is ignored, both in the current frame and in later frames.
- R6: `frame_start` while `busy` is high is ignored. It neither restarts nor adds a frame.
- R7: A new frame may start in the cycle right after the last serial bit of the previous frame. Carries left over from the previous frame do not affect the new product.
- R8: Extreme operands give correct products: the most negative value on either side or on both sides, the maximum positive values, and -1 times -1.
- R9: While `prod_valid` is 0, `prod_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_load | input | 1 | Capture `op_in` into the operand register (idle only) |
| op_in | input | M | Signed register operand |
| frame_start | input | 1 | Marks serial bit 0 of a new frame |
| ser_in | input | 1 | Serial operand bit, LSB first, sign-extended to M+N bits |
| prod_bit | output | 1 | Serial product bit, LSB first |
| prod_valid | output | 1 | `prod_bit` holds a product bit |
| prod_first | output | 1 | `prod_bit` is product bit 0 |
| busy | output | 1 | Controller is in ST_RUN |

## Verification
The hardest case to reach from the ports is a frame that starts in the very cycle after a previous frame's last bit, while the cells still hold nonzero saved carries. Only a correct clear on the strobe keeps the new product clean. The stimulus runs a chain of back-to-back frames with negative serial operands, so the most significant cell's borrow and the lower cells' carries are left set. Separate frames pulse `op_load` and `frame_start` in the middle of a frame. The scoreboard then shows that the product and the frame count stay unchanged and that the old operand persists into the next frame.

// File: rtl/spm_pkg.sv
package spm_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } spm_state_t;
endpackage

// File: rtl/spm_cell.sv
module spm_cell #(
    parameter bit NEG = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clr,
    input  logic a_bit,
    input  logic x_bit,
    input  logic s_in,
    output logic s_out
);
    logic s_q, c_q;
    logic pp, op, cin, si, sum, cout;

    always_comb begin
        pp   = a_bit & x_bit;
        op   = NEG ? ~pp : pp;
        // a new frame starts from zero partial sum; the negating cell seeds +1
        cin  = clr ? NEG : c_q;
        si   = clr ? 1'b0 : s_in;
        sum  = op ^ si ^ cin;
        cout = (op & si) | (op & cin) | (si & cin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= 1'b0;
            c_q <= 1'b0;
        end else if (step) begin
            s_q <= sum;
            c_q <= cout;
        end
    end

    assign s_out = s_q;
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
    import spm_pkg::*;
#(
    parameter int L = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic step,
    output logic clr,
    output logic busy,
    output logic valid_q,
    output logic first_q
);
    localparam int CW = $clog2(L + 1);

    spm_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and step strobes
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        step    = 1'b0;
        clr     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    step  = 1'b1;
                    clr   = 1'b1;
                    cnt_d = CW'(1);
                    if (L > 1) state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (cnt_q == CW'(L - 1)) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
        endcase
    end

    // registered output flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            first_q <= 1'b0;
        end else begin
            valid_q <= step;
            first_q <= clr;
        end
    end

    assign busy = (state_q == ST_RUN);

    // run-length counter used only by the checks below
    logic [CW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (first_q) run_q <= CW'(1);
        else if (valid_q) run_q <= run_q + CW'(1);
    end

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !first_q) |-> (run_q < CW'(L)));  // R4
    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_q) |-> (run_q == CW'(L)));  // R4
endmodule

// File: rtl/serial_par_mult.sv
module serial_par_mult #(
    parameter int M = 8,
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_load,
    input  logic [M-1:0] op_in,
    input  logic         frame_start,
    input  logic         ser_in,
    output logic         prod_bit,
    output logic         prod_valid,
    output logic         prod_first,
    output logic         busy
);
    localparam int L = M + N;

    logic [M-1:0] op_q;
    logic [M-1:0] s_chain;
    logic         step, clr, valid_q, first_q;

    spm_ctrl #(.L(L)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (frame_start),
        .step   (step),
        .clr    (clr),
        .busy   (busy),
        .valid_q(valid_q),
        .first_q(first_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              op_q <= '0;
        else if (op_load && !busy && !frame_start) op_q <= op_in;
    end

    for (genvar i = 0; i < M; i++) begin : g_cell
        logic nb;
        if (i == M - 1) begin : g_top
            assign nb = 1'b0;
        end else begin : g_mid
            assign nb = s_chain[i+1];
        end
        spm_cell #(.NEG(i == M - 1)) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .step (step),
            .clr  (clr),
            .a_bit(op_q[i]),
            .x_bit(ser_in),
            .s_in (nb),
            .s_out(s_chain[i])
        );
    end

    assign prod_bit   = valid_q & s_chain[0];
    assign prod_valid = valid_q;
    assign prod_first = first_q;

    AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_q));  // R5
    AST_FIRST_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !busy) |=> (prod_first && prod_valid));  // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && busy) |=> !prod_first);  // R6
endmodule

// File: tb/test_serial_par_mult.sv
module test_serial_par_mult;
    localparam int M = 8;
    localparam int N = 8;
    localparam int L = M + N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_load = 1'b0;
    logic [M-1:0] op_in = '0;
    logic         frame_start = 1'b0;
    logic         ser_in = 1'b0;
    logic         prod_bit, prod_valid, prod_first, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [L-1:0] exp_prod[$];
    int           exp_cyc[$];
    string        exp_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_par_mult #(.M(M), .N(N)) i_serial_par_mult (
        .clk(clk), .rst_n(rst_n), .op_load(op_load), .op_in(op_in),
        .frame_start(frame_start), .ser_in(ser_in),
        .prod_bit(prod_bit), .prod_valid(prod_valid),
        .prod_first(prod_first), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one frame, expected product pushed to the scoreboard
    task automatic run_frame(input logic [M-1:0] a, input logic [N-1:0] b, input bit do_load,
                             input bit mid_load, input bit mid_start, input string tag);
        logic [L-1:0] bx;
        longint       p;
        bx = {{M{b[N-1]}}, b};
        if (do_load) begin
            @(negedge clk);
            op_load = 1'b1;
            op_in   = a;
            @(negedge clk);
            op_load = 1'b0;
        end else begin
            @(negedge clk);
        end
        p = longint'($signed(a)) * longint'($signed(b));
        exp_prod.push_back(p[L-1:0]);
        exp_cyc.push_back(cyc + 1);
        exp_tag.push_back(tag);
        frame_start = 1'b1;
        ser_in      = bx[0];
        for (int t = 1; t < L; t++) begin
            @(negedge clk);
            frame_start = 1'b0;
            op_load     = 1'b0;
            ser_in      = bx[t];
            if (mid_load && t == 5) begin
                op_load = 1'b1;
                op_in   = ~a;
            end
            if (mid_start && t == 7) frame_start = 1'b1;
        end
    endtask

    task automatic finish_frame;
        @(negedge clk);
        frame_start = 1'b0;
        op_load     = 1'b0;
        ser_in      = 1'b0;
    endtask

    // monitor: reassemble the serial product and compare
    bit           infrm = 1'b0;
    int           nbits = 0;
    logic [L-1:0] acc = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prod_valid) begin
                if (prod_first) begin
                    check(!infrm, "R4 frame cut short", 64'(nbits), 64'(L));
                    if (exp_cyc.size() == 0) begin
                        check(1'b0, "R6 unexpected frame", 64'(cyc), 64'(0));
                    end else begin
                        int ec;
                        ec = exp_cyc.pop_front();
                        check(cyc == ec, "R3 first bit cycle", 64'(cyc), 64'(ec));
                    end
                    infrm = 1'b1;
                    nbits = 0;
                    acc   = '0;
                end else if (!infrm) begin
                    check(1'b0, "R4 valid beyond frame", 64'(cyc), 64'(0));
                end
                if (infrm) begin
                    acc[nbits] = prod_bit;
                    nbits++;
                    if (nbits == L) begin
                        logic [L-1:0] ep;
                        string        tg;
                        infrm = 1'b0;
                        if (exp_prod.size() == 0) begin
                            check(1'b0, "R2 no expected product", 64'(acc), 64'(0));
                        end else begin
                            ep = exp_prod.pop_front();
                            tg = exp_tag.pop_front();
                            check(acc == ep, {"R2 product ", tg}, 64'(acc), 64'(ep));
                        end
                    end
                end
            end else begin
                check(!infrm, "R4 valid dropped early", 64'(nbits), 64'(L));
                infrm = 1'b0;
                check(prod_bit == 1'b0, "R9 bit while not valid", 64'(prod_bit), 64'(0));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && prod_valid == 1'b0, "R1 reset flags", 64'({busy, prod_valid}), 64'(0));
        check(prod_first == 1'b0 && prod_bit == 1'b0, "R1 reset outputs", 64'({prod_first, prod_bit}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, prod_valid, prod_first, prod_bit} == 4'b0, "R1 after reset", 64'({busy, prod_valid, prod_first, prod_bit}), 64'(0));

        // R8 extreme operands
        run_frame(8'h80, 8'h80, 1, 0, 0, "R8 min*min");   finish_frame();
        run_frame(8'h80, 8'h7F, 1, 0, 0, "R8 min*max");   finish_frame();
        run_frame(8'h7F, 8'h80, 1, 0, 0, "R8 max*min");   finish_frame();
        run_frame(8'h7F, 8'h7F, 1, 0, 0, "R8 max*max");   finish_frame();
        run_frame(8'hFF, 8'hFF, 1, 0, 0, "R8 -1*-1");     finish_frame();
        run_frame(8'h00, 8'h80, 1, 0, 0, "R8 0*min");     finish_frame();

        // R7 back-to-back frames, carries left set by negative operands
        run_frame(8'hB3, 8'hFF, 1, 0, 0, "R7 b2b a");
        run_frame(8'hB3, 8'h80, 0, 0, 0, "R7 b2b b");
        run_frame(8'hB3, 8'hFD, 0, 0, 0, "R7 b2b c");
        run_frame(8'hB3, 8'h01, 0, 0, 0, "R7 b2b d");
        finish_frame();

        // R5 load during a frame ignored now and later
        run_frame(8'h5A, 8'hC7, 1, 1, 0, "R5 mid load");  finish_frame();
        run_frame(8'h5A, 8'h13, 0, 0, 0, "R5 old operand kept"); finish_frame();

        // R6 start during a frame ignored
        run_frame(8'hE1, 8'h6B, 1, 0, 1, "R6 mid start"); finish_frame();

        // R2 random operands, some back to back
        for (int k = 0; k < 24; k++) begin
            logic [M-1:0] ra;
            logic [N-1:0] rb;
            ra = M'($urandom);
            rb = N'($urandom);
            run_frame(ra, rb, 1, 0, 0, "R2 random");
            run_frame(ra, N'($urandom), 0, 0, 0, "R2 random same A");
            if (k % 3 == 0) finish_frame();
        end
        finish_frame();

        repeat (L + 4) @(negedge clk);
        check(exp_prod.size() == 0, "R4 frames outstanding", 64'(exp_prod.size()), 64'(0));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule